// File: doc/BRIEF.md
# Video Data-Enable Frame Monitor

This block sits in the pixel-clock domain. It watches a data-enable line together with 24-bit RGB pixel data and splits the stream into frames. A frame boundary is the point where data-enable has stayed low for a configurable number of consecutive pixel clocks. No sync input is used to find it.

Within a frame the block counts the active lines and measures how many pixel clocks each line stays active. It also captures the colour of the first active pixel. It compares the frame against an expected line count and an expected line width.

When the frame closes, the block raises a one-cycle strobe. With it the block presents the line count, the width of the last line, a mismatch flag and the captured pixel. These results are held until the next strobe, so a slower consumer can sample them at any point in between.

Top module: `frame_watch`

## Requirements
- R1: While reset is low and after its release, `frame_done` and `anomaly` are 0, and `line_cnt`, `line_width` and the three `head_*` outputs are 0. Reset is asynchronous and active low.
- R2: `line_cnt` reports the number of rising edges of `de` between the start of a frame and its end.
- R3: A frame ends when `de` has been sampled low on `GAP_LEN` consecutive clock edges. `frame_done` is 1 in the cycle that follows the edge that samples the `GAP_LEN`-th low. A low run of `GAP_LEN-1` clocks or fewer does not end the frame.
- R4: Between two `frame_done` pulses, the values of `line_cnt`, `line_width`, `anomaly` and `head_*` do not change.
- R5: `frame_done` lasts exactly one cycle. A gap that follows no active line produces no pulse.
- R6: `anomaly` is 1 when the reported line count differs from `LINES_EXP`.
- R7: `line_width` is the number of high `de` cycles in the last line of the frame. `anomaly` is also 1 when any line of the frame had a width other than `WIDTH_EXP`. This mismatch memory clears when a new frame starts, so a clean frame that follows a bad one reports `anomaly` = 0.
- R8: `head_r`, `head_g` and `head_b` carry `px_r`, `px_g` and `px_b` as they were sampled on the first high `de` cycle of the frame.
- R9: If `de` is already high when reset is released, that partial line is not counted. The first frame starts at the first rising edge of `de` after reset.
- R10: The gap counter saturates at `GAP_LEN`. However long `de` stays low, a gap yields at most one `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| de | input | 1 | Data enable |
| px_r | input | 8 | Red pixel byte |
| px_g | input | 8 | Green pixel byte |
| px_b | input | 8 | Blue pixel byte |
| frame_done | output | 1 | One-cycle strobe at frame end |
| line_cnt | output | CW | Active lines in the last frame |
| line_width | output | CW | Width of the last line of the last frame |
| anomaly | output | 1 | Line count or any line width off its expected value |
| head_r | output | 8 | Red byte of the first pixel of the last frame |
| head_g | output | 8 | Green byte of the first pixel of the last frame |
| head_b | output | 8 | Blue byte of the first pixel of the last frame |

## Verification
Let E be the clock edge that samples the last high `de` of a frame. The strobe is due exactly `GAP_LEN` edges after E. The bench drives `de` low on the falling edge that follows E and then counts falling edges. It requires `frame_done` to be 0 on the first `GAP_LEN-1` of them, to be 1 on the `GAP_LEN`-th, and to be 0 again on the next one. All result fields are compared on the same falling edge as the strobe, against values that the bench derived from the line widths and pixels it drove. Just before each expected strobe, the bench also compares the outputs against the previous report.

// File: rtl/frame_watch.sv
module frame_watch #(
  parameter int LINES_EXP = 800,
  parameter int WIDTH_EXP = 1280,
  parameter int GAP_LEN   = 2048,
  parameter int CW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          de,
  input  logic [7:0]    px_r,
  input  logic [7:0]    px_g,
  input  logic [7:0]    px_b,
  output logic          frame_done,
  output logic [CW-1:0] line_cnt,
  output logic [CW-1:0] line_width,
  output logic          anomaly,
  output logic [7:0]    head_r,
  output logic [7:0]    head_g,
  output logic [7:0]    head_b
);
  localparam int GW = $clog2(GAP_LEN + 1);
  localparam logic [GW-1:0] GAP_TOP  = GW'(GAP_LEN);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_LEN - 1);
  localparam logic [CW-1:0] CMAX     = {CW{1'b1}};
  localparam logic [CW-1:0] L_EXP    = CW'(LINES_EXP);
  localparam logic [CW-1:0] W_EXP    = CW'(WIDTH_EXP);

  logic          de_q, active, wbad;
  logic [GW-1:0] gap;
  logic [CW-1:0] lcnt, wcnt;
  logic [23:0]   cap;

  wire rise    = de & ~de_q;
  wire end_hit = ~de & (gap == GAP_LAST) & active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q       <= 1'b1;
      active     <= 1'b0;
      wbad       <= 1'b0;
      gap        <= '0;
      lcnt       <= '0;
      wcnt       <= '0;
      cap        <= '0;
      frame_done <= 1'b0;
      line_cnt   <= '0;
      line_width <= '0;
      anomaly    <= 1'b0;
      {head_r, head_g, head_b} <= '0;
    end else begin
      de_q       <= de;
      frame_done <= 1'b0;
      if (de)                 gap <= '0;
      else if (gap != GAP_TOP) gap <= gap + 1'b1;
      if (rise) begin
        active <= 1'b1;
        wcnt   <= CW'(1);
        if (!active) begin
          lcnt <= CW'(1);
          wbad <= 1'b0;
          cap  <= {px_r, px_g, px_b};
        end else begin
          if (lcnt != CMAX) lcnt <= lcnt + 1'b1;
          if (wcnt != W_EXP) wbad <= 1'b1;
        end
      end else if (de && active && wcnt != CMAX) begin
        wcnt <= wcnt + 1'b1;
      end
      if (end_hit) begin
        frame_done <= 1'b1;
        active     <= 1'b0;
        line_cnt   <= lcnt;
        line_width <= wcnt;
        anomaly    <= (lcnt != L_EXP) | (wcnt != W_EXP) | wbad;
        {head_r, head_g, head_b} <= cap;
      end
    end
  end

  AST_GAP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    gap <= GAP_TOP); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R5
  AST_DONE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !$past(de)); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable({line_cnt, line_width, anomaly, head_r, head_g, head_b})); // R4
  AST_LINE_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && line_cnt != L_EXP) |-> anomaly); // R6
  AST_WIDTH_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && line_width != W_EXP) |-> anomaly); // R7
endmodule

// File: tb/sim_frame_watch.sv
module sim_frame_watch;
  localparam int LE = 4;
  localparam int WE = 6;
  localparam int GP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic de = 1'b0;
  logic [7:0] px_r = '0, px_g = '0, px_b = '0;
  logic frame_done, anomaly;
  logic [15:0] line_cnt, line_width;
  logic [7:0] head_r, head_g, head_b;

  int n_chk = 0, n_fail = 0;
  int prev_l = 0, prev_w = 0, prev_a = 0, prev_px = 0;
  int first_px, last_w;
  bit any_bad;
  int widths[8];

  always #4 clk = ~clk;

  frame_watch #(.LINES_EXP(LE), .WIDTH_EXP(WE), .GAP_LEN(GP), .CW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .de(de), .px_r(px_r), .px_g(px_g), .px_b(px_b),
    .frame_done(frame_done), .line_cnt(line_cnt), .line_width(line_width),
    .anomaly(anomaly), .head_r(head_r), .head_g(head_g), .head_b(head_b));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_anom(input int nl);
    return (nl != LE || any_bad) ? 1 : 0;
  endfunction

  task automatic idle(input int n, input string tag);
    int seen = 0;
    de = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (frame_done) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic drive_lines(input int nl, input int hb, output int early);
    early = 0;
    any_bad = 1'b0;
    for (int l = 0; l < nl; l++) begin
      for (int c = 0; c < widths[l]; c++) begin
        de = 1'b1;
        px_r = 8'($urandom); px_g = 8'($urandom); px_b = 8'($urandom);
        if (l == 0 && c == 0) first_px = {8'h0, px_r, px_g, px_b};
        @(negedge clk);
        if (frame_done) early++;
      end
      if (widths[l] != WE) any_bad = 1'b1;
      last_w = widths[l];
      if (l != nl - 1) begin
        for (int c = 0; c < hb; c++) begin
          de = 1'b0;
          @(negedge clk);
          if (frame_done) early++;
        end
      end
    end
    de = 1'b0;
  endtask

  task automatic wait_end(input int nl, input int early);
    int pre = early;
    chk(line_cnt == 16'(prev_l) && line_width == 16'(prev_w) && anomaly == prev_a[0]
        && {head_r, head_g, head_b} == 24'(prev_px), "R4 hold", line_cnt, prev_l);
    for (int i = 1; i < GP; i++) begin
      @(negedge clk);
      if (frame_done) pre++;
    end
    chk(pre == 0, "R3 no early strobe", pre, 0);
    @(negedge clk);
    chk(frame_done == 1'b1, "R3 strobe timing", frame_done, 1);
    chk(line_cnt == 16'(nl), "R2 line count", line_cnt, nl);
    chk(line_width == 16'(last_w), "R7 last width", line_width, last_w);
    chk(anomaly == exp_anom(nl)[0], "R6/R7 anomaly", anomaly, exp_anom(nl));
    chk({head_r, head_g, head_b} == 24'(first_px), "R8 first pixel",
        {head_r, head_g, head_b}, first_px);
    prev_l = nl; prev_w = last_w; prev_a = exp_anom(nl); prev_px = first_px;
    @(negedge clk);
    chk(frame_done == 1'b0, "R5 single cycle", frame_done, 0);
  endtask

  task automatic frame(input int nl, input int badl, input int badw, input int hb);
    int e;
    for (int l = 0; l < 8; l++) widths[l] = (l == badl) ? badw : WE;
    drive_lines(nl, hb, e);
    wait_end(nl, e);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(frame_done == 0 && line_cnt == 0 && line_width == 0 && anomaly == 0
        && {head_r, head_g, head_b} == 0, "R1 in reset", line_cnt, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(frame_done == 0 && line_cnt == 0 && anomaly == 0, "R1 after release", frame_done, 0);
    idle(3 * GP, "R5 empty gap no strobe");

    frame(LE, -1, 0, 2);
    frame(LE, 0, WE + 2, 3);
    frame(LE, -1, 0, 1);
    frame(LE + 1, -1, 0, 2);
    frame(LE, LE - 1, WE - 3, 2);
    frame(LE, -1, 0, GP - 1);
    idle(4 * GP, "R10 long gap single strobe");
    frame(1, -1, 0, 1);

    for (int k = 0; k < 20; k++) begin
      int nl = 3 + int'($urandom % 3);
      int bl = ($urandom % 4 == 0) ? int'($urandom % 32'(nl)) : -1;
      int bw = ($urandom % 2 == 0) ? WE + 1 : WE - 2;
      int hb = 1 + int'($urandom % (GP - 1));
      frame(nl, bl, bw, hb);
    end

    de = 1'b1;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    prev_l = 0; prev_w = 0; prev_a = 0; prev_px = 0;
    repeat (4) @(negedge clk);
    de = 1'b0;
    repeat (2) @(negedge clk);
    frame(LE, -1, 0, 2);
    chk(line_cnt == 16'(LE), "R9 partial line ignored", line_cnt, LE);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule